// File: doc/BRIEF.md
# Dual byte FIFO with trigger interrupts

This block sits between a simple register bus and a serial-bus sequencer. It keeps one byte queue per direction. Software fills the transmit queue through a data register and the sequencer drains it. The sequencer fills the receive queue and software drains it through a second data register. Each queue is switched on by its own control bit. While a queue is switched off it is held empty.

Two programmable thresholds raise "almost empty" (transmit) and "almost full" (receive) events. Writes to a full queue, reads from an empty queue and pushes or pops past the limits are flagged as overrun or underrun errors. A small idle timer flags receive bytes that have sat below the receive threshold for a programmed number of quiet cycles. The software can then collect a tail that would never reach the threshold.

All events collect in a sticky status register that software clears by writing ones. An enable mask selects which status bits drive the single interrupt line. The queue depth is a parameter and must be a power of two no larger than 64. Both 16 and 64 are intended settings.

Top module: `dual_fifo_irq`

## Requirements
- R1: After reset both queues are empty and disabled. The interrupt status reads 0, the enable mask reads 0, the control register reads 0, the idle limit reads 15 and `irq` is low.
- R2: Register map by word index on `reg_addr`: 0 control, 1 interrupt enable, 2 interrupt status, 3 levels, 4 transmit data (write), 5 receive data (read), 6 idle limit (bits 3:0). Bytes written to index 4 leave on `tx_byte` in write order, and `tx_valid` is high while the transmit queue holds data. Bytes pushed with `rx_push` are returned by reads of index 5 in push order.
- R3: The levels word holds the transmit level in bits 6:0, transmit full at bit 7 and transmit empty at bit 8. It holds the receive level in bits 22:16, receive full at bit 23 and receive empty at bit 24. All other bits read 0. A queue is full when its level equals the depth.
- R4: A transmit-data write to an enabled full queue is dropped and sets status bit 3.
- R5: A `tx_pop` on an enabled empty transmit queue sets status bit 2.
- R6: An `rx_push` into an enabled full receive queue is dropped and sets status bit 5.
- R7: A receive-data read of an empty or disabled queue returns 0. If the queue is enabled, the read also sets status bit 4.
- R8: Control bits 10:4 hold the receive threshold and bits 22:16 the transmit threshold. In any cycle where the transmit queue is enabled and its level is at or below its threshold, status bit 0 is set at the next edge. In any cycle where the receive queue is enabled and its level is at or above its threshold, status bit 1 is set at the next edge.
- R9: Status bit 6 (trailing) is set once, and only after a quiet stretch. The stretch requires the receive queue to be enabled and to hold between 1 and threshold-1 bytes, with no push and no receive-data read. The bit is set at the edge ending the (L+1)-th such cycle, where L is the idle limit.
- R10: A write to status clears exactly the bits written as 1 and leaves the others. A set event in the same cycle wins over the clear.
- R11: `irq` is high exactly when some status bit and its enable bit (same position in register 1) are both 1.
- R12: Control bit 0 enables the receive queue and bit 1 the transmit queue. A disabled queue is emptied at the next edge and ignores writes, pushes, pops and reads. It raises no error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops receive data at index 5) |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid in the cycle of `reg_rd` |
| tx_pop | input | 1 | Sequencer takes the head transmit byte |
| tx_byte | output | 8 | Head transmit byte, 0 when empty or disabled |
| tx_valid | output | 1 | Transmit queue holds data |
| rx_push | input | 1 | Sequencer delivers a receive byte |
| rx_byte | input | 8 | Receive byte delivered with `rx_push` |
| irq | output | 1 | Combined masked interrupt |

## Verification
The hardest situation to reach is the trailing event. It needs a receive queue that is enabled and partly filled below its threshold, with the bus and sequencer both quiet for exactly the programmed number of cycles. Any access to the receive data register restarts the count. The bench reaches it with a directed sequence: a single push against a high threshold, followed by idle-only cycles, with the interrupt line watched through a mask that selects only the trailing bit, one cycle before and one cycle at the expected edge. Full-queue overruns, empty-queue underruns and threshold crossings are driven both by directed fill-and-drain runs and by a long seeded random mix that also toggles the enables and thresholds mid-stream.

// File: rtl/dual_fifo_pkg.sv
package dual_fifo_pkg;
  localparam int WORD_W = 32;
  localparam int SEL_W  = 3;
  localparam int IRQ_N  = 7;
  localparam int TRIG_W = 7;
  localparam int LIM_W  = 4;

  localparam logic [SEL_W-1:0] A_CTRL   = 3'd0;
  localparam logic [SEL_W-1:0] A_IEN    = 3'd1;
  localparam logic [SEL_W-1:0] A_ISTAT  = 3'd2;
  localparam logic [SEL_W-1:0] A_LEVELS = 3'd3;
  localparam logic [SEL_W-1:0] A_TXD    = 3'd4;
  localparam logic [SEL_W-1:0] A_RXD    = 3'd5;
  localparam logic [SEL_W-1:0] A_LIMIT  = 3'd6;

  localparam int C_RXEN   = 0;
  localparam int C_TXEN   = 1;
  localparam int C_RXTRIG = 4;
  localparam int C_TXTRIG = 16;

  localparam int B_TX_AE  = 0;
  localparam int B_RX_AF  = 1;
  localparam int B_TX_UND = 2;
  localparam int B_TX_OVR = 3;
  localparam int B_RX_UND = 4;
  localparam int B_RX_OVR = 5;
  localparam int B_TRAIL  = 6;
endpackage

// File: rtl/byte_queue.sv
module byte_queue #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [CW-1:0] level,
  output logic          full,
  output logic          empty
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, wr_ptr_n, rd_ptr, rd_ptr_n;
  logic [CW-1:0] cnt, cnt_n;
  logic          do_push, do_pop;

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign level   = cnt;
  assign do_push = en && push && !full;
  assign do_pop  = en && pop && !empty;
  assign head    = (en && !empty) ? mem[rd_ptr] : '0;

  always_comb begin
    wr_ptr_n = wr_ptr;
    rd_ptr_n = rd_ptr;
    cnt_n    = cnt;
    if (!en) begin
      wr_ptr_n = '0;
      rd_ptr_n = '0;
      cnt_n    = '0;
    end else begin
      if (do_push) wr_ptr_n = wr_ptr + 1'b1;
      if (do_pop)  rd_ptr_n = rd_ptr + 1'b1;
      cnt_n = cnt + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      wr_ptr <= wr_ptr_n;
      rd_ptr <= rd_ptr_n;
      cnt    <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end
endmodule

// File: rtl/idle_timer.sv
module idle_timer #(
  parameter int LIM_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             active,
  input  logic             pending,
  input  logic [LIM_W-1:0] limit,
  output logic             hit
);
  logic [LIM_W-1:0] cnt, cnt_n;
  logic             fired, fired_n;
  logic             quiet;

  assign quiet = en && pending && !active;
  assign hit   = quiet && (cnt == limit) && !fired;

  always_comb begin
    cnt_n   = cnt;
    fired_n = fired;
    if (!quiet) begin
      cnt_n   = '0;
      fired_n = 1'b0;
    end else if (cnt == limit) begin
      fired_n = 1'b1;
    end else begin
      cnt_n = cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      fired <= 1'b0;
    end else begin
      cnt   <= cnt_n;
      fired <= fired_n;
    end
  end
endmodule

// File: rtl/dual_fifo_irq.sv
module dual_fifo_irq
  import dual_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int LVL_W = $clog2(DEPTH) + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic                 reg_rd,
  input  logic [SEL_W-1:0]     reg_addr,
  input  logic [WORD_W-1:0]    reg_wdata,
  output logic [WORD_W-1:0]    reg_rdata,
  input  logic                 tx_pop,
  output logic [7:0]           tx_byte,
  output logic                 tx_valid,
  input  logic                 rx_push,
  input  logic [7:0]           rx_byte,
  output logic                 irq
);
  // configuration and status registers
  logic              rx_en_q, rx_en_n, tx_en_q, tx_en_n;
  logic [TRIG_W-1:0] rx_trig_q, rx_trig_n, tx_trig_q, tx_trig_n;
  logic [IRQ_N-1:0]  ien_q, ien_n, istat_q, istat_n;
  logic [LIM_W-1:0]  lim_q, lim_n;

  logic wr_ctrl, wr_ien, wr_istat, wr_lim, wr_txd, rd_rxd;
  logic [LVL_W-1:0]  tx_level, rx_level;
  logic [TRIG_W-1:0] tx_lvl7, rx_lvl7;
  logic              tx_full, tx_empty, rx_full, rx_empty;
  logic [7:0]        rx_head;
  logic              trail_hit, rx_pending;
  logic [IRQ_N-1:0]  set_vec, clr_vec;
  logic              unused_wdata;

  assign wr_ctrl  = reg_wr && (reg_addr == A_CTRL);
  assign wr_ien   = reg_wr && (reg_addr == A_IEN);
  assign wr_istat = reg_wr && (reg_addr == A_ISTAT);
  assign wr_lim   = reg_wr && (reg_addr == A_LIMIT);
  assign wr_txd   = reg_wr && (reg_addr == A_TXD);
  assign rd_rxd   = reg_rd && (reg_addr == A_RXD);

  byte_queue #(.DEPTH(DEPTH), .DW(8)) u_txq (
    .clk(clk), .rst_n(rst_n), .en(tx_en_q),
    .push(wr_txd), .push_data(reg_wdata[7:0]), .pop(tx_pop),
    .head(tx_byte), .level(tx_level), .full(tx_full), .empty(tx_empty)
  );

  byte_queue #(.DEPTH(DEPTH), .DW(8)) u_rxq (
    .clk(clk), .rst_n(rst_n), .en(rx_en_q),
    .push(rx_push), .push_data(rx_byte), .pop(rd_rxd),
    .head(rx_head), .level(rx_level), .full(rx_full), .empty(rx_empty)
  );

  assign tx_lvl7    = TRIG_W'(tx_level);
  assign rx_lvl7    = TRIG_W'(rx_level);
  assign rx_pending = !rx_empty && (rx_lvl7 < rx_trig_q);

  idle_timer #(.LIM_W(LIM_W)) u_trail (
    .clk(clk), .rst_n(rst_n), .en(rx_en_q),
    .active(rx_push || rd_rxd), .pending(rx_pending),
    .limit(lim_q), .hit(trail_hit)
  );

  // event collection
  always_comb begin
    set_vec           = '0;
    set_vec[B_TX_AE]  = tx_en_q && (tx_lvl7 <= tx_trig_q);
    set_vec[B_RX_AF]  = rx_en_q && (rx_lvl7 >= rx_trig_q);
    set_vec[B_TX_UND] = tx_pop && tx_en_q && tx_empty;
    set_vec[B_TX_OVR] = wr_txd && tx_en_q && tx_full;
    set_vec[B_RX_UND] = rd_rxd && rx_en_q && rx_empty;
    set_vec[B_RX_OVR] = rx_push && rx_en_q && rx_full;
    set_vec[B_TRAIL]  = trail_hit;
    clr_vec           = wr_istat ? reg_wdata[IRQ_N-1:0] : '0;
  end

  always_comb begin
    rx_en_n   = rx_en_q;
    tx_en_n   = tx_en_q;
    rx_trig_n = rx_trig_q;
    tx_trig_n = tx_trig_q;
    ien_n     = ien_q;
    lim_n     = lim_q;
    if (wr_ctrl) begin
      rx_en_n   = reg_wdata[C_RXEN];
      tx_en_n   = reg_wdata[C_TXEN];
      rx_trig_n = reg_wdata[C_RXTRIG +: TRIG_W];
      tx_trig_n = reg_wdata[C_TXTRIG +: TRIG_W];
    end
    if (wr_ien) ien_n = reg_wdata[IRQ_N-1:0];
    if (wr_lim) lim_n = reg_wdata[LIM_W-1:0];
    istat_n = (istat_q & ~clr_vec) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_en_q   <= 1'b0;
      tx_en_q   <= 1'b0;
      rx_trig_q <= '0;
      tx_trig_q <= '0;
      ien_q     <= '0;
      istat_q   <= '0;
      lim_q     <= '1;
    end else begin
      rx_en_q   <= rx_en_n;
      tx_en_q   <= tx_en_n;
      rx_trig_q <= rx_trig_n;
      tx_trig_q <= tx_trig_n;
      ien_q     <= ien_n;
      istat_q   <= istat_n;
      lim_q     <= lim_n;
    end
  end

  // read mux
  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      case (reg_addr)
        A_CTRL:   reg_rdata = {9'b0, tx_trig_q, 5'b0, rx_trig_q, 2'b0, tx_en_q, rx_en_q};
        A_IEN:    reg_rdata = {25'b0, ien_q};
        A_ISTAT:  reg_rdata = {25'b0, istat_q};
        A_LEVELS: reg_rdata = {7'b0, rx_empty, rx_full, rx_lvl7,
                               7'b0, tx_empty, tx_full, tx_lvl7};
        A_RXD:    reg_rdata = {24'b0, rx_head};
        A_LIMIT:  reg_rdata = {28'b0, lim_q};
        default:  reg_rdata = '0;
      endcase
    end
  end

  assign tx_valid     = !tx_empty;
  assign irq          = |(istat_q & ien_q);
  assign unused_wdata = ^{reg_wdata[31:23], reg_wdata[15:11], reg_wdata[3:2]};
endmodule

// File: rtl/dual_fifo_irq_chk.sv
module dual_fifo_irq_chk
  import dual_fifo_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [SEL_W-1:0]  reg_addr,
  input logic [WORD_W-1:0] reg_rdata,
  input logic              tx_pop,
  input logic              rx_push,
  input logic              tx_en,
  input logic              rx_en,
  input logic              tx_full,
  input logic              tx_empty,
  input logic              rx_full,
  input logic              rx_empty,
  input logic [IRQ_N-1:0]  istat,
  input logic              irq
);
  logic rd_rx_strobe;
  assign rd_rx_strobe = reg_rd && (reg_addr == A_RXD);

  AST_TX_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_TXD && tx_en && tx_full && !tx_pop) |=> (istat[B_TX_OVR] && tx_full)); // R4

  AST_TX_UNDERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_pop && tx_en && tx_empty) |=> istat[B_TX_UND]); // R5

  AST_RX_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && rx_en && rx_full && !rd_rx_strobe) |=> (istat[B_RX_OVR] && rx_full)); // R6

  AST_RX_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rx_strobe && rx_empty) |-> (reg_rdata == '0)); // R7

  AST_RX_UNDERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rx_strobe && rx_en && rx_empty) |=> istat[B_RX_UND]); // R7

  AST_TX_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en) |=> tx_empty); // R12

  AST_RX_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en) |=> rx_empty); // R12

  AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (istat != '0)); // R11

  AST_TRAIL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(istat[B_TRAIL]) |-> (!rx_empty && !$past(rx_push) && !$past(rd_rx_strobe))); // R9
endmodule

bind dual_fifo_irq dual_fifo_irq_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_addr(reg_addr), .reg_rdata(reg_rdata), .tx_pop(tx_pop), .rx_push(rx_push),
  .tx_en(tx_en_q), .rx_en(rx_en_q), .tx_full(tx_full), .tx_empty(tx_empty),
  .rx_full(rx_full), .rx_empty(rx_empty), .istat(istat_q), .irq(irq)
);

// File: tb/dual_fifo_irq_test.sv
module dual_fifo_irq_test;
  localparam int DEPTH = 16;
  localparam logic [2:0] A_CTRL = 3'd0, A_IEN = 3'd1, A_ISTAT = 3'd2,
                         A_LEVELS = 3'd3, A_TXD = 3'd4, A_RXD = 3'd5, A_LIMIT = 3'd6;
  localparam int OP_IDLE = 0, OP_WR = 1, OP_RD = 2, OP_POP = 3, OP_PUSH = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr, reg_rd, tx_pop, rx_push;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata, dummy;
  logic [7:0]  tx_byte, rx_byte;
  logic        tx_valid, irq;

  always #10 clk = ~clk;

  dual_fifo_irq #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_pop(tx_pop), .tx_byte(tx_byte),
    .tx_valid(tx_valid), .rx_push(rx_push), .rx_byte(rx_byte), .irq(irq)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // reference model
  logic [7:0] mtx[$];
  logic [7:0] mrx[$];
  bit         m_txen = 0, m_rxen = 0;
  int         m_ttrig = 0, m_rtrig = 0;
  logic [6:0] m_ist = '0, m_ien = '0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [31:0] exp_levels();
    int tl = mtx.size();
    int rl = mrx.size();
    return {7'b0, rl == 0, rl == DEPTH, 7'(rl), 7'b0, tl == 0, tl == DEPTH, 7'(tl)};
  endfunction

  task automatic cycle(input int op, input logic [2:0] addr, input logic [31:0] wd,
                       output logic [31:0] rd);
    logic [6:0] s, clr;
    bit pre_tx, pre_rx;
    int tl, rl;
    s = '0; clr = '0; rd = '0;
    pre_tx = m_txen; pre_rx = m_rxen; tl = mtx.size(); rl = mrx.size();
    if (pre_tx && tl <= m_ttrig) s[0] = 1'b1;
    if (pre_rx && rl >= m_rtrig) s[1] = 1'b1;
    case (op)
      OP_WR: begin
        reg_wr = 1'b1; reg_addr = addr; reg_wdata = wd;
        if (addr == A_TXD && pre_tx) begin
          if (tl == DEPTH) s[3] = 1'b1;
          else mtx.push_back(wd[7:0]);
        end
        if (addr == A_ISTAT) clr = wd[6:0];
      end
      OP_RD: begin
        reg_rd = 1'b1; reg_addr = addr;
        #1 rd = reg_rdata;
        if (addr == A_RXD) begin
          if (pre_rx && rl > 0) begin
            chk("R2 rx order", rd, {24'b0, mrx[0]});
            void'(mrx.pop_front());
          end else begin
            chk("R7 empty read", rd, 32'h0);
            if (pre_rx) s[4] = 1'b1;
          end
        end
      end
      OP_POP: begin
        tx_pop = 1'b1;
        #1;
        if (pre_tx) begin
          if (tl == 0) s[2] = 1'b1;
          else begin
            chk("R2 tx order", {24'b0, tx_byte}, {24'b0, mtx[0]});
            void'(mtx.pop_front());
          end
        end
      end
      OP_PUSH: begin
        rx_push = 1'b1; rx_byte = wd[7:0];
        if (pre_rx) begin
          if (rl == DEPTH) s[5] = 1'b1;
          else mrx.push_back(wd[7:0]);
        end
      end
      default: ;
    endcase
    tick;
    reg_wr = 1'b0; reg_rd = 1'b0; tx_pop = 1'b0; rx_push = 1'b0;
    if (!pre_tx) mtx.delete();
    if (!pre_rx) mrx.delete();
    m_ist = (m_ist & ~clr) | s;
    if (op == OP_WR && addr == A_CTRL) begin
      m_rxen = wd[0]; m_txen = wd[1];
      m_rtrig = int'(wd[10:4]); m_ttrig = int'(wd[22:16]);
    end
    if (op == OP_WR && addr == A_IEN) m_ien = wd[6:0];
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    cycle(OP_WR, a, d, dummy);
  endtask

  // compares irq, levels word and status (trailing bit masked)
  task automatic check_state(input string tag);
    logic [31:0] e, r;
    chk({tag, " irq"}, {31'b0, irq}, {31'b0, |(m_ist & m_ien)});
    e = exp_levels();
    cycle(OP_RD, A_LEVELS, 0, r);
    chk({tag, " levels"}, r, e);
    e = {25'b0, m_ist};
    cycle(OP_RD, A_ISTAT, 0, r);
    chk({tag, " status"}, r & 32'h3F, e & 32'h3F);
  endtask

  function automatic logic [31:0] ctrl_word(bit rxen, bit txen, int rtrig, int ttrig);
    return (32'(ttrig) << 16) | (32'(rtrig) << 4) | {30'b0, txen, rxen};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    reg_wr = 0; reg_rd = 0; tx_pop = 0; rx_push = 0;
    reg_addr = '0; reg_wdata = '0; rx_byte = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick;

    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 32'h0);
    cycle(OP_RD, A_LEVELS, 0, r); chk("R1 levels", r, 32'h0100_0100);
    cycle(OP_RD, A_ISTAT, 0, r);  chk("R1 status", r, 32'h0);
    cycle(OP_RD, A_IEN, 0, r);    chk("R1 enable", r, 32'h0);
    cycle(OP_RD, A_CTRL, 0, r);   chk("R1 control", r, 32'h0);
    cycle(OP_RD, A_LIMIT, 0, r);  chk("R1 limit", r, 32'hF);

    // R12 disabled queues ignore everything
    wr(A_TXD, 32'hA5);
    cycle(OP_PUSH, 0, 32'h5A, dummy);
    cycle(OP_POP, 0, 0, dummy);
    cycle(OP_RD, A_RXD, 0, r);
    check_state("R12");
    chk("R12 tx_valid", {31'b0, tx_valid}, 32'h0);

    // enable, thresholds tx 4 rx 12; R8 control readback
    wr(A_CTRL, ctrl_word(1, 1, 12, 4));
    cycle(OP_RD, A_CTRL, 0, r); chk("R8 control", r, ctrl_word(1, 1, 12, 4));

    // R3/R4 fill transmit queue, overrun
    for (int i = 0; i < DEPTH; i++) wr(A_TXD, 32'(8'h10 + i));
    check_state("R3");
    chk("R2 tx_valid", {31'b0, tx_valid}, 32'h1);
    wr(A_TXD, 32'hEE);
    check_state("R4");

    // R10 write back read value clears those bits only
    cycle(OP_RD, A_ISTAT, 0, r);
    wr(A_ISTAT, r);
    check_state("R10");
    wr(A_ISTAT, 32'h0);
    check_state("R10 zero write");

    // R11 enable mask
    wr(A_TXD, 32'hEF);
    wr(A_IEN, 32'h08);
    check_state("R11");
    chk("R11 irq high", {31'b0, irq}, 32'h1);
    wr(A_IEN, 32'h10);
    chk("R11 irq low", {31'b0, irq}, 32'h0);
    wr(A_IEN, 32'h0);

    // R8 almost-empty: drain to 5, clear, then cross to 4
    for (int i = 0; i < DEPTH - 5; i++) cycle(OP_POP, 0, 0, dummy);
    wr(A_ISTAT, 32'h7F);
    check_state("R8 above trigger");
    cycle(OP_POP, 0, 0, dummy);
    cycle(OP_IDLE, 0, 0, dummy);
    check_state("R8 at trigger");

    // R2/R5 drain transmit, underrun
    for (int i = 0; i < 4; i++) cycle(OP_POP, 0, 0, dummy);
    cycle(OP_POP, 0, 0, dummy);
    check_state("R5");

    // R6 receive overrun, R8 almost-full
    for (int i = 0; i < DEPTH; i++) cycle(OP_PUSH, 0, 32'(8'hC0 + i), dummy);
    check_state("R8 rx");
    cycle(OP_PUSH, 0, 32'h77, dummy);
    check_state("R6");
    for (int i = 0; i < DEPTH; i++) cycle(OP_RD, A_RXD, 0, dummy);
    cycle(OP_RD, A_RXD, 0, dummy);
    check_state("R7");

    // R12 disable flushes a filled queue without flags
    wr(A_ISTAT, 32'h7F);
    cycle(OP_PUSH, 0, 32'h11, dummy);
    cycle(OP_PUSH, 0, 32'h22, dummy);
    wr(A_CTRL, ctrl_word(0, 0, 12, 4));
    cycle(OP_IDLE, 0, 0, dummy);
    cycle(OP_RD, A_RXD, 0, dummy);
    check_state("R12 flush");

    // R9 trailing: limit 3, one byte below threshold 8
    wr(A_CTRL, ctrl_word(1, 0, 8, 0));
    wr(A_LIMIT, 32'h3);
    wr(A_IEN, 32'h40);
    wr(A_ISTAT, 32'h7F);
    cycle(OP_PUSH, 0, 32'h3C, dummy);
    for (int i = 0; i < 3; i++) cycle(OP_IDLE, 0, 0, dummy);
    chk("R9 before limit", {31'b0, irq}, 32'h0);
    cycle(OP_IDLE, 0, 0, dummy);
    chk("R9 at limit", {31'b0, irq}, 32'h1);
    wr(A_ISTAT, 32'h40);
    repeat (6) cycle(OP_IDLE, 0, 0, dummy);
    chk("R9 fires once", {31'b0, irq}, 32'h0);
    wr(A_IEN, 32'h0);
    cycle(OP_RD, A_RXD, 0, dummy);
    wr(A_ISTAT, 32'h7F);

    // seeded random mix
    void'($urandom(32'd20240611));
    wr(A_CTRL, ctrl_word(1, 1, DEPTH / 2, DEPTH / 4));
    for (int i = 0; i < 4000; i++) begin
      int sel;
      sel = $urandom_range(0, 99);
      if (sel < 25) wr(A_TXD, 32'($urandom_range(0, 255)));
      else if (sel < 45) cycle(OP_POP, 0, 0, dummy);
      else if (sel < 65) cycle(OP_PUSH, 0, 32'($urandom_range(0, 255)), dummy);
      else if (sel < 85) cycle(OP_RD, A_RXD, 0, dummy);
      else if (sel < 88) wr(A_CTRL, ctrl_word($urandom_range(0, 9) != 0, $urandom_range(0, 9) != 0,
                                              $urandom_range(1, DEPTH), $urandom_range(0, DEPTH)));
      else if (sel < 91) wr(A_ISTAT, 32'($urandom_range(0, 127)));
      else if (sel < 93) wr(A_IEN, 32'($urandom_range(0, 63)));
      else if (sel < 96) check_state("R2 random");
      else cycle(OP_IDLE, 0, 0, dummy);
    end
    check_state("R11 random end");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule